// File: doc/BRIEF.md
# Binary Float to FP4 e2m1 Encoder

This block narrows one IEEE-style binary floating-point word per cycle to a 4-bit e2m1 code. Rounding is always round-to-nearest with ties to the even code, and no other mode can be selected. The format has eight magnitudes per sign. The smallest nonzero step, 0.5, is a subnormal code that the block produces as an ordinary result and never flushes. The source format is set by two parameters. The defaults give binary32, and smaller settings give narrower sources such as binary16.

A valid strobe goes in with each word. The result is registered and comes out one clock later with its own valid strobe. The output register loads only on a valid cycle, so the code stays put while the input is idle. The e2m1 format has no infinity or NaN encodings. Overflow and infinity saturate to the largest magnitude, and a NaN input gives positive zero.

Top module: `e2m1_encoder`

## Requirements
- R1: The code carries the sign in bit 3, a bias-1 exponent in bits 2:1 and a mantissa in bit 0. Magnitude codes 0 to 7 stand for 0, 0.5, 1, 1.5, 2, 3, 4 and 6. For every non-NaN input, bit 3 equals the input sign, and a finite input maps to the nearest of these magnitudes.
- R2: An input with magnitude strictly between 0.25 and 0.75 produces magnitude code 1 (exponent field 0, mantissa 1, value 0.5) with the input sign.
- R3: An input with magnitude 0.25 or less produces magnitude code 0 with the input sign. This includes both zeros and all source subnormals.
- R4: An input exactly halfway between two grid points goes to the code whose bit 0 is 0. So 0.25 gives 0, 0.75 gives 1, 1.25 gives 1, 2.5 gives 2 and 5 gives 4.
- R5: Rounding up from the top of one exponent band carries into the next band. 1.75 gives code 4 (2.0) and 3.5 gives code 6 (4.0).
- R6: A finite magnitude above 5, and also an infinity, produces magnitude code 7 (6.0) with the input sign.
- R7: A NaN input (exponent field all ones, mantissa nonzero) produces code 0000.
- R8: valid_o equals valid_i delayed by one clock, and code_o holds the result for the word that was presented in that earlier cycle.
- R9: While valid_i is low, code_o keeps its previous value.
- R10: While rst_ni is low, valid_o is 0 and code_o is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid this cycle |
| data_i | input | 1+EXP_W+MAN_W | Source float: sign, exponent, mantissa |
| valid_o | output | 1 | Registered result is valid |
| code_o | output | 4 | e2m1 code: sign, 2-bit exponent, 1-bit mantissa |

## Verification
The bench builds the encoder with a 5-bit exponent and a 10-bit mantissa, which is a half-precision source. With that setting all 65536 input words can be swept one per cycle. The sweep covers every tie point, every band carry, every source subnormal, both zeros, both infinities and every NaN payload. Each expected code comes from real-valued nearest-grid arithmetic in the bench. Directed words then pin the named corner values, the hold behaviour and the reset state.

// File: rtl/e2m1_pkg.sv
package e2m1_pkg;

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_TINY = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef struct packed {
    logic       sign;
    logic [2:0] mag;
  } e2m1_t;

  localparam logic [2:0] MAG_ZERO = 3'd0;
  localparam logic [2:0] MAG_MAX  = 3'd7;

  // round-to-nearest-even increment from kept lsb, round bit and sticky
  function automatic logic rne_up(input logic lsb, input logic rnd, input logic stk);
    return rnd & (stk | lsb);
  endfunction

endpackage

// File: rtl/e2m1_unpack.sv
module e2m1_unpack
  import e2m1_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input  logic [W-1:0]           data_i,
  output logic                   sign_o,
  output cls_e                   cls_o,
  output logic signed [EXP_W:0]  uexp_o,
  output logic [MAN_W-1:0]       man_o
);

  localparam logic signed [EXP_W:0] BIAS_S = BIAS[EXP_W:0];

  logic [EXP_W-1:0] exp_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_nz;

  assign sign_o   = data_i[W-1];
  assign exp_f    = data_i[W-2 -: EXP_W];
  assign man_o    = data_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_o;
  assign uexp_o   = $signed({1'b0, exp_f}) - BIAS_S;

  always_comb begin
    if (exp_ones) cls_o = man_nz ? CLS_NAN : CLS_INF;
    else if (exp_zero) cls_o = CLS_TINY;  // source zero/subnormal is far below 0.25
    else cls_o = CLS_NORM;
  end

endmodule

// File: rtl/e2m1_round.sv
module e2m1_round
  import e2m1_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  cls_e                   cls_i,
  input  logic signed [EXP_W:0]  uexp_i,
  input  logic [MAN_W-1:0]       man_i,
  output logic [2:0]             mag_o
);

  localparam logic signed [EXP_W:0] E_SAT   = 3;   // 8.0 and above
  localparam logic signed [EXP_W:0] E_NRM   = 0;   // lowest normal band [1,2)
  localparam logic signed [EXP_W:0] E_HALF  = -1;  // [0.5,1)
  localparam logic signed [EXP_W:0] E_QUART = -2;  // [0.25,0.5)

  logic m_hi, m_rnd, m_stk;

  assign m_hi  = man_i[MAN_W-1];
  assign m_rnd = man_i[MAN_W-2];

  generate
    if (MAN_W > 2) begin : g_stk
      assign m_stk = |man_i[MAN_W-3:0];
    end else begin : g_no_stk
      assign m_stk = 1'b0;
    end
  endgenerate

  // normal branch: keep one mantissa bit, carry may move into next band
  logic       nrm_up;
  logic [1:0] nrm_ef;
  logic [3:0] nrm_sum;
  logic [2:0] nrm_mag;

  assign nrm_up  = rne_up(m_hi, m_rnd, m_stk);
  assign nrm_ef  = uexp_i[1:0] + 2'd1;
  assign nrm_sum = {1'b0, nrm_ef, m_hi} + {3'b000, nrm_up};
  assign nrm_mag = nrm_sum[3] ? MAG_MAX : nrm_sum[2:0];

  // subnormal branch: align significand to the 0.5 step, same RNE
  logic       sub_keep, sub_rnd, sub_stk, sub_up;
  logic [1:0] sub_sum;
  logic [2:0] sub_mag;

  always_comb begin
    if (uexp_i == E_HALF) begin
      sub_keep = 1'b1;
      sub_rnd  = m_hi;
      sub_stk  = m_rnd | m_stk;
    end else begin
      sub_keep = 1'b0;
      sub_rnd  = 1'b1;
      sub_stk  = m_hi | m_rnd | m_stk;
    end
  end

  assign sub_up  = rne_up(sub_keep, sub_rnd, sub_stk);
  assign sub_sum = {1'b0, sub_keep} + {1'b0, sub_up};
  assign sub_mag = {1'b0, sub_sum};  // 2 lands on code 010 = 1.0

  always_comb begin
    unique case (cls_i)
      CLS_NAN:  mag_o = MAG_ZERO;
      CLS_INF:  mag_o = MAG_MAX;
      CLS_TINY: mag_o = MAG_ZERO;
      default: begin
        if (uexp_i >= E_SAT)        mag_o = MAG_MAX;
        else if (uexp_i >= E_NRM)   mag_o = nrm_mag;
        else if (uexp_i >= E_QUART) mag_o = sub_mag;
        else                        mag_o = MAG_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/e2m1_encoder.sv
module e2m1_encoder
  import e2m1_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [3:0]   code_o
);

  logic                  in_sign;
  cls_e                  in_cls;
  logic signed [EXP_W:0] in_uexp;
  logic [MAN_W-1:0]      in_man;
  logic [2:0]            rnd_mag;
  e2m1_t                 res;

  e2m1_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .data_i (data_i),
    .sign_o (in_sign),
    .cls_o  (in_cls),
    .uexp_o (in_uexp),
    .man_o  (in_man)
  );

  e2m1_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .cls_i  (in_cls),
    .uexp_i (in_uexp),
    .man_i  (in_man),
    .mag_o  (rnd_mag)
  );

  assign res.sign = (in_cls == CLS_NAN) ? 1'b0 : in_sign;
  assign res.mag  = rnd_mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= 4'b0000;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= res;
    end
  end

endmodule

// File: rtl/e2m1_encoder_chk.sv
module e2m1_encoder_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] data_i,
  input logic         valid_o,
  input logic [3:0]   code_o
);

  logic [EXP_W-1:0] ef;
  logic             is_nan, is_inf, is_tiny;

  assign ef      = data_i[W-2 -: EXP_W];
  assign is_nan  = (&ef) && (|data_i[MAN_W-1:0]);
  assign is_inf  = (&ef) && !(|data_i[MAN_W-1:0]);
  assign is_tiny = int'(ef) < (BIAS - 2);

  // R8
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o));
  // R7
  nan_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_nan) |=> (code_o == 4'b0000));
  // R6
  inf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_inf) |=> (code_o[2:0] == 3'b111 && code_o[3] == $past(data_i[W-1])));
  // R3
  tiny_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_tiny) |=> (code_o[2:0] == 3'b000));
  // R1
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_nan) |=> (code_o[3] == $past(data_i[W-1])));

endmodule

bind e2m1_encoder e2m1_encoder_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .data_i  (data_i),
  .valid_o (valid_o),
  .code_o  (code_o)
);

// File: tb/sim_e2m1_encoder.sv
module sim_e2m1_encoder;

  localparam int EW = 5;
  localparam int MW = 10;
  localparam int W  = 1 + EW + MW;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_o;
  logic [3:0]   code_o;

  int checks = 0;
  int failures = 0;

  always #2ns clk_i = ~clk_i;

  e2m1_encoder #(.EXP_W(EW), .MAN_W(MW)) u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .code_o  (code_o)
  );

  function automatic real grid(input int k);
    case (k)
      0: return 0.0;  1: return 0.5;  2: return 1.0;  3: return 1.5;
      4: return 2.0;  5: return 3.0;  6: return 4.0;  default: return 6.0;
    endcase
  endfunction

  function automatic bit is_nan(input logic [W-1:0] h);
    return (&h[W-2 -: EW]) && (|h[MW-1:0]);
  endfunction

  function automatic bit is_inf(input logic [W-1:0] h);
    return (&h[W-2 -: EW]) && !(|h[MW-1:0]);
  endfunction

  function automatic real mag_of(input logic [W-1:0] h);
    int e;
    real f;
    e = int'(h[W-2 -: EW]);
    f = real'(h[MW-1:0]) / 1024.0;
    if (e == 0) return f * (2.0 ** (-14));
    return (1.0 + f) * (2.0 ** (e - 15));
  endfunction

  function automatic logic [3:0] expect_code(input logic [W-1:0] h);
    real m, mid;
    int  q;
    bit  found;
    if (is_nan(h)) return 4'b0000;
    if (is_inf(h)) return {h[W-1], 3'b111};
    m = mag_of(h);
    q = 7;
    found = 0;
    for (int k = 0; k < 7; k++) begin
      mid = (grid(k) + grid(k + 1)) / 2.0;
      if (!found && m < mid) begin
        q = k; found = 1;
      end else if (!found && m == mid) begin
        q = (k % 2 == 0) ? k : k + 1; found = 1;
      end
    end
    return {h[W-1], 3'(q)};
  endfunction

  function automatic string tag_of(input logic [W-1:0] h);
    real m;
    if (is_nan(h)) return "R7";
    if (is_inf(h)) return "R6";
    m = mag_of(h);
    if (m > 5.0) return "R6";
    if (m <= 0.25) return "R3";
    for (int k = 0; k < 7; k++)
      if (m == (grid(k) + grid(k + 1)) / 2.0) return "R4";
    if ((m > 1.75 && m < 2.0) || (m > 3.5 && m < 4.0)) return "R5";
    if (m < 0.75) return "R2";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic one(input logic [W-1:0] h, input string tag, input logic [3:0] exp_c);
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = h;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R8", {7'd0, valid_o}, 8'd1);
    chk(tag, {4'd0, code_o}, {4'd0, exp_c});
  endtask

  initial begin
    #600us;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    logic [3:0]   held;
    // R10
    repeat (3) @(negedge clk_i);
    chk("R10", {7'd0, valid_o}, 8'd0);
    chk("R10", {4'd0, code_o}, 8'd0);
    rst_ni = 1'b1;

    // exhaustive sweep, one word per cycle
    prev = '0;
    for (int i = 0; i < (1 << W); i++) begin
      @(negedge clk_i);
      if (i > 0) chk(tag_of(prev), {4'd0, code_o}, {4'd0, expect_code(prev)});
      valid_i = 1'b1;
      data_i  = W'(i);
      prev    = W'(i);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(tag_of(prev), {4'd0, code_o}, {4'd0, expect_code(prev)});

    // directed corners (half-precision encodings)
    one(16'h3400, "R4", 4'b0000);  // 0.25
    one(16'h3401, "R2", 4'b0001);  // just above 0.25
    one(16'hB800, "R2", 4'b1001);  // -0.5
    one(16'h3A00, "R4", 4'b0010);  // 0.75
    one(16'h3D00, "R4", 4'b0010);  // 1.25
    one(16'h4100, "R4", 4'b0100);  // 2.5
    one(16'h4500, "R4", 4'b0110);  // 5
    one(16'h3F00, "R5", 4'b0100);  // 1.75
    one(16'h4300, "R5", 4'b0110);  // 3.5
    one(16'h4680, "R6", 4'b0111);  // 6.5
    one(16'hFC00, "R6", 4'b1111);  // -inf
    one(16'hFE00, "R7", 4'b0000);  // NaN with sign set
    one(16'h8000, "R3", 4'b1000);  // -0
    one(16'h0001, "R3", 4'b0000);  // smallest subnormal
    one(16'hC200, "R1", 4'b1101);  // -3

    // R9: idle cycle with different data leaves code unchanged
    held = code_o;
    @(negedge clk_i);
    valid_i = 1'b0;
    data_i  = 16'h4500;
    @(negedge clk_i);
    chk("R9", {4'd0, code_o}, {4'd0, held});
    chk("R8", {7'd0, valid_o}, 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule